// File: doc/BRIEF.md
# APB Requester Transfer Sequencer

This block is the requester side of an APB link. Local logic hands it one transfer at a time: an address, a direction flag, write data and a one-cycle start strobe. The block then walks the bus through its idle, setup and access phases, driving select, enable, address, direction and write data. It holds the transfer for as long as the subordinate keeps ready low.

Every result is taken on one clock edge only: the edge where select, enable and ready are all high. On that edge the block registers the read data (reads only) and the error response (reads and writes). It also registers the count of low ready samples seen in the access phase. One cycle later it raises a done pulse. A start that arrives on the completion edge chains directly into a new setup phase. A start at any other time during a transfer is dropped.

Top module: `apb_xfer_seq`

## Requirements
- R1: A start sampled while idle moves the bus, on the next cycle, into a single setup cycle (pSel=1, pEnable=0). The cycle after that is the first access cycle (pSel=1, pEnable=1).
- R2: Each low pReady sample in the access phase holds the access: pSel and pEnable stay high, and the bus never goes back to setup.
- R3: pAddr, pWrite and pWdata keep the values taken at start through the whole setup and access phases, including every wait cycle.
- R4: Completion is the single edge where pSel, pEnable and pReady are all high. In the following cycle rspDone is high for exactly one cycle, and pSel and pEnable are low unless R8 applies.
- R5: rspRdata takes pRdata only on the completion edge of a read. Data on wait edges, and any write transfer, leave it unchanged.
- R6: rspErr takes pSlvErr on the completion edge of every transfer, read or write.
- R7: rspWaits equals the number of low pReady samples before the completing high sample, and is 0 when ready is high on the first access edge.
- R8: A start present on the completion edge is accepted. The next cycle is then a setup cycle for the new command, with no idle cycle in between.
- R9: busy is high in every setup and access cycle and low while idle. A start during setup or during a wait cycle is ignored and changes no bus signal.
- R10: While rstN is low at a clock edge, the block goes idle with pSel and pEnable low, and clears rspRdata, rspErr, rspWaits and rspDone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| reqStart | input | 1 | Start strobe for a new transfer |
| reqAddr | input | ADDR_W | Transfer address |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWdata | input | DATA_W | Write data |
| pSel | output | 1 | Bus select |
| pEnable | output | 1 | Bus enable (access phase) |
| pAddr | output | ADDR_W | Bus address |
| pWrite | output | 1 | Bus direction |
| pWdata | output | DATA_W | Bus write data |
| pReady | input | 1 | Subordinate ready |
| pRdata | input | DATA_W | Subordinate read data |
| pSlvErr | input | 1 | Subordinate error response |
| rspRdata | output | DATA_W | Captured read data |
| rspErr | output | 1 | Captured error flag |
| rspDone | output | 1 | One-cycle completion pulse |
| rspWaits | output | WCNT_W | Wait states counted in the last transfer |
| busy | output | 1 | Transfer in progress |

## Verification
Assume a start is sampled at edge k and n low ready samples follow. The setup outputs appear after edge k and the first access cycle after edge k+1. The completion edge is k+2+n. rspDone, rspRdata, rspErr and rspWaits all change after that edge and are read in the cycle that follows it. The bench drives inputs and samples outputs at falling edges, so each check falls in the cycle its register is due. The sweep covers wait counts 0 to 5 for both directions and both error values. During wait cycles the bench presents wrong read data and an inverted error, so a capture on the wrong edge shows up as a mismatch.

// File: rtl/apb_seq_pkg.sv
package apb_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACCESS = 2'd2
  } phase_t;

  typedef struct packed {
    logic loadCmd;   // latch a new command, clear wait count
    logic waitTick;  // low ready sample in access
    logic complete;  // select & enable & ready edge
  } seqStrobe_t;

endpackage

// File: rtl/apb_seq_ctrl.sv
module apb_seq_ctrl
  import apb_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqStart,
  input  logic       pReady,
  output logic       pSel,
  output logic       pEnable,
  output logic       busy,
  output seqStrobe_t strobe
);

  phase_t phase, phaseNext;

  always_comb begin
    phaseNext = phase;
    strobe    = '0;
    unique case (phase)
      PH_IDLE: begin
        if (reqStart) begin
          strobe.loadCmd = 1'b1;
          phaseNext      = PH_SETUP;
        end
      end
      PH_SETUP: phaseNext = PH_ACCESS;
      PH_ACCESS: begin
        if (pReady) begin
          strobe.complete = 1'b1;
          if (reqStart) begin
            strobe.loadCmd = 1'b1;
            phaseNext      = PH_SETUP;
          end else begin
            phaseNext = PH_IDLE;
          end
        end else begin
          strobe.waitTick = 1'b1;
        end
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  assign pSel    = (phase == PH_SETUP) || (phase == PH_ACCESS);
  assign pEnable = (phase == PH_ACCESS);
  assign busy    = (phase != PH_IDLE);

endmodule

// File: rtl/apb_seq_dpath.sv
module apb_seq_dpath
  import apb_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int WCNT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] pRdata,
  input  logic              pSlvErr,
  output logic [ADDR_W-1:0] pAddr,
  output logic              pWrite,
  output logic [DATA_W-1:0] pWdata,
  output logic [DATA_W-1:0] rspRdata,
  output logic              rspErr,
  output logic              rspDone,
  output logic [WCNT_W-1:0] rspWaits
);

  localparam logic [WCNT_W-1:0] WCNT_MAX = {WCNT_W{1'b1}};

  logic [WCNT_W-1:0] waitCnt;

  // Command hold registers: change only when a command is accepted.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pAddr  <= '0;
      pWrite <= 1'b0;
      pWdata <= '0;
    end else if (strobe.loadCmd) begin
      pAddr  <= reqAddr;
      pWrite <= reqWrite;
      pWdata <= reqWdata;
    end
  end

  // Wait-state counter, saturating.
  always_ff @(posedge clk) begin
    if (!rstN || strobe.loadCmd) waitCnt <= '0;
    else if (strobe.waitTick && waitCnt != WCNT_MAX) waitCnt <= waitCnt + 1'b1;
  end

  // Response capture, gated on the completion edge only.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspRdata <= '0;
      rspErr   <= 1'b0;
      rspDone  <= 1'b0;
      rspWaits <= '0;
    end else begin
      rspDone <= strobe.complete;
      if (strobe.complete) begin
        rspErr   <= pSlvErr;
        rspWaits <= waitCnt;
        if (!pWrite) rspRdata <= pRdata;
      end
    end
  end

endmodule

// File: rtl/apb_xfer_seq.sv
module apb_xfer_seq
  import apb_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int WCNT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqStart,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              pSel,
  output logic              pEnable,
  output logic [ADDR_W-1:0] pAddr,
  output logic              pWrite,
  output logic [DATA_W-1:0] pWdata,
  input  logic              pReady,
  input  logic [DATA_W-1:0] pRdata,
  input  logic              pSlvErr,
  output logic [DATA_W-1:0] rspRdata,
  output logic              rspErr,
  output logic              rspDone,
  output logic [WCNT_W-1:0] rspWaits,
  output logic              busy
);

  seqStrobe_t strobe;

  apb_seq_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .reqStart(reqStart),
    .pReady  (pReady),
    .pSel    (pSel),
    .pEnable (pEnable),
    .busy    (busy),
    .strobe  (strobe)
  );

  apb_seq_dpath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .WCNT_W(WCNT_W)
  ) dpath_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .reqAddr (reqAddr),
    .reqWrite(reqWrite),
    .reqWdata(reqWdata),
    .pRdata  (pRdata),
    .pSlvErr (pSlvErr),
    .pAddr   (pAddr),
    .pWrite  (pWrite),
    .pWdata  (pWdata),
    .rspRdata(rspRdata),
    .rspErr  (rspErr),
    .rspDone (rspDone),
    .rspWaits(rspWaits)
  );

endmodule

// File: rtl/apb_xfer_seq_chk.sv
module apb_xfer_seq_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int WCNT_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              pSel,
  input logic              pEnable,
  input logic [ADDR_W-1:0] pAddr,
  input logic              pWrite,
  input logic [DATA_W-1:0] pWdata,
  input logic              pReady,
  input logic [DATA_W-1:0] pRdata,
  input logic              pSlvErr,
  input logic [DATA_W-1:0] rspRdata,
  input logic              rspErr,
  input logic              rspDone,
  input logic [WCNT_W-1:0] rspWaits,
  input logic              busy
);

  assert_setup_to_access_R1: assert property (@(posedge clk) disable iff (!rstN)
    (pSel && !pEnable) |=> (pSel && pEnable));

  assert_enable_needs_select_R1: assert property (@(posedge clk) disable iff (!rstN)
    pEnable |-> pSel);

  assert_wait_holds_access_R2: assert property (@(posedge clk) disable iff (!rstN)
    (pSel && pEnable && !pReady) |=> (pSel && pEnable));

  assert_wait_keeps_bus_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pSel && pEnable && !pReady) |=> ($stable(pAddr) && $stable(pWrite) && $stable(pWdata)));

  assert_setup_keeps_bus_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pSel && !pEnable) |=> ($stable(pAddr) && $stable(pWrite) && $stable(pWdata)));

  assert_done_after_complete_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pSel && pEnable && pReady) |=> rspDone);

  assert_done_only_after_complete_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pSel && pEnable && !pReady) |=> !rspDone);

  assert_read_capture_R5: assert property (@(posedge clk) disable iff (!rstN)
    (pSel && pEnable && pReady && !pWrite) |=> (rspRdata == $past(pRdata)));

  assert_write_keeps_rdata_R5: assert property (@(posedge clk) disable iff (!rstN)
    (pSel && pEnable && pReady && pWrite) |=> $stable(rspRdata));

  assert_err_capture_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pSel && pEnable && pReady) |=> (rspErr == $past(pSlvErr)));

  assert_zero_wait_count_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pSel && pEnable && pReady && $past(pSel && !pEnable)) |=> (rspWaits == '0));

  assert_busy_with_select_R9: assert property (@(posedge clk) disable iff (!rstN)
    busy == pSel);

endmodule

bind apb_xfer_seq apb_xfer_seq_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .WCNT_W(WCNT_W)
) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .pSel    (pSel),
  .pEnable (pEnable),
  .pAddr   (pAddr),
  .pWrite  (pWrite),
  .pWdata  (pWdata),
  .pReady  (pReady),
  .pRdata  (pRdata),
  .pSlvErr (pSlvErr),
  .rspRdata(rspRdata),
  .rspErr  (rspErr),
  .rspDone (rspDone),
  .rspWaits(rspWaits),
  .busy    (busy)
);

// File: tb/apb_xfer_seq_tb.sv
`timescale 1ns/1ps
module apb_xfer_seq_tb_top;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int WCNT_W = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqStart = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic              reqWrite = 1'b0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic              pSel, pEnable, pWrite;
  logic [ADDR_W-1:0] pAddr;
  logic [DATA_W-1:0] pWdata;
  logic              pReady = 1'b0;
  logic [DATA_W-1:0] pRdata = '0;
  logic              pSlvErr = 1'b0;
  logic [DATA_W-1:0] rspRdata;
  logic              rspErr, rspDone, busy;
  logic [WCNT_W-1:0] rspWaits;

  int checks = 0;
  int errors = 0;
  logic [DATA_W-1:0] expRd = '0;

  always #2 clk = ~clk;

  apb_xfer_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WCNT_W(WCNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .reqStart(reqStart), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqWdata(reqWdata), .pSel(pSel), .pEnable(pEnable),
    .pAddr(pAddr), .pWrite(pWrite), .pWdata(pWdata), .pReady(pReady),
    .pRdata(pRdata), .pSlvErr(pSlvErr), .rspRdata(rspRdata), .rspErr(rspErr),
    .rspDone(rspDone), .rspWaits(rspWaits), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Present a junk start that must be ignored.
  task automatic junkStart();
    reqStart = 1'b1;
    reqAddr  = 8'hEE;
    reqWrite = 1'b1;
    reqWdata = 16'hDEAD;
  endtask

  // Called at a falling edge while idle; returns at the falling edge in setup.
  task automatic startXfer(input bit wr, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] wd);
    reqStart = 1'b1; reqAddr = a; reqWrite = wr; reqWdata = wd;
    @(negedge clk);
    check(pSel && !pEnable, "R1", {pSel, pEnable}, 2'b10);
    check(busy, "R9", busy, 1);
    check(pAddr == a && pWrite == wr && pWdata == wd, "R3", pAddr, a);
    junkStart();  // ignored during setup (R9)
  endtask

  // Called at a falling edge in setup; returns at the falling edge after completion.
  task automatic finishXfer(input bit wr, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] wd,
                            input int waits, input bit err, input logic [DATA_W-1:0] rd,
                            input bit chain, input logic [ADDR_W-1:0] ca);
    for (int i = 0; i <= waits; i++) begin
      @(negedge clk);
      check(pSel && pEnable, "R2", {pSel, pEnable}, 2'b11);
      check(pAddr == a && pWrite == wr && pWdata == wd, "R3", pAddr, a);
      check(!rspDone, "R4", rspDone, 0);
      pReady  = (i == waits);
      pRdata  = (i == waits) ? rd : ~rd;
      pSlvErr = (i == waits) ? err : ~err;
      if (i < waits) junkStart();  // ignored during wait (R9)
      else if (chain) begin
        reqStart = 1'b1; reqAddr = ca; reqWrite = 1'b0; reqWdata = '0;
      end else reqStart = 1'b0;
    end
    @(negedge clk);
    pReady = 1'b0; reqStart = 1'b0;
    if (!wr) expRd = rd;
    check(rspDone, "R4", rspDone, 1);
    check(rspRdata == expRd, "R5", rspRdata, expRd);
    check(rspErr == err, "R6", rspErr, err);
    check(rspWaits == WCNT_W'(waits), "R7", rspWaits, waits);
    if (chain) begin
      check(pSel && !pEnable && pAddr == ca, "R8", {pSel, pEnable, pAddr}, {2'b10, ca});
    end else begin
      check(!pSel && !pEnable, "R4", {pSel, pEnable}, 0);
      check(!busy, "R9", busy, 0);
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check(!pSel && !pEnable && !busy, "R10", {pSel, pEnable, busy}, 0);
    check(rspRdata == 0 && !rspErr && !rspDone && rspWaits == 0, "R10", rspRdata, 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int w = 0; w <= 5; w++) begin
      for (int wr = 0; wr < 2; wr++) begin
        for (int e = 0; e < 2; e++) begin
          logic [ADDR_W-1:0] a;
          logic [DATA_W-1:0] wd, rd;
          a  = ADDR_W'(w * 16 + wr * 4 + e + 1);
          wd = DATA_W'(16'h1000 + w * 37 + wr * 5 + e);
          rd = DATA_W'(16'h5A00 + w * 11 + e * 3 + wr);
          startXfer(wr[0], a, wd);
          finishXfer(wr[0], a, wd, w, e[0], rd, 1'b0, '0);
          @(negedge clk);
          check(!rspDone, "R4", rspDone, 0);
        end
      end
    end

    // R8: chained transfer on the completion edge
    startXfer(1'b0, 8'h31, 16'h0);
    finishXfer(1'b0, 8'h31, 16'h0, 2, 1'b0, 16'hBEEF, 1'b1, 8'h42);
    finishXfer(1'b0, 8'h42, 16'h0, 1, 1'b1, 16'hCAFE, 1'b0, '0);

    // R10: reset after activity
    startXfer(1'b0, 8'h07, 16'h0);
    finishXfer(1'b0, 8'h07, 16'h0, 3, 1'b1, 16'h1234, 1'b0, '0);
    rstN = 1'b0;
    @(negedge clk);
    check(rspRdata == 0 && !rspErr && rspWaits == 0 && !rspDone, "R10", rspRdata, 0);
    check(!pSel && !pEnable, "R10", {pSel, pEnable}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule